// File: doc/BRIEF.md
# Vectored Interrupt Controller

The controller gathers up to 32 interrupt sources into one request line for a processor. Each source sets a bit in a status register. A build-time parameter chooses, per source, how that bit behaves. A level source's bit copies the input. An edge source's bit is set by a rising input and stays set until software clears it. Status ANDed with an enable register gives the pending set. A priority encoder turns the pending set into a vector number, and the lowest index wins.

The processor uses a word-indexed register port. Writes take effect on the clock edge, and reads return the current value in the same cycle. Enable bits can be replaced as a whole, or set and cleared atomically through write-one aliases. Status bits are acknowledged with a write-one-to-clear alias. A two-bit master control separately gates the capture of inputs (bit 1) and the request line (bit 0).

Register word indices, with byte address = index x 4: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master control.

Top module: `vec_intc`

## Requirements
- R1: Synchronous active-high reset clears status, enable and master control. After reset, every readable register returns 0 except the vector, which returns 32'hFFFF_FFFF, and `irq_o` is low.
- R2: Pending always equals status AND enable. A write to pending (byte 0x04) or vector (byte 0x18) leaves no lasting effect.
- R3: Vector reads the index of the lowest-numbered pending bit, so bit 0 has the highest priority. With nothing pending, vector reads 32'hFFFF_FFFF.
- R4: `irq_o` is high exactly when master bit 0 is 1, master bit 1 is 1 and at least one pending bit is set.
- R5: A write to acknowledge (byte 0x0C) clears each status bit whose written bit is 1 and leaves the other status bits as they are.
- R6: A write to set-enable (0x10) ORs the value into enable. A write to clear-enable (0x14) clears each enable bit whose written bit is 1. Neither write changes any other register.
- R7: Writes to status (0x00), enable (0x08) and master (0x1C) store the value. Reads return the stored value. Acknowledge, set-enable and clear-enable read as 0. A byte address of 0x20 or above reads as 0, and a write to it changes nothing.
- R8: While capture is on, a level source's status bit takes the input value on every clock.
- R9: While capture is on, a rising input (input 1, registered previous input 0) on an edge source sets its status bit. The bit is cleared only by acknowledge or a status write. An input held high does not set it again. If a capture and an acknowledge hit the same bit in the same cycle, the capture wins.
- R10: While master bit 1 is 0, status ignores input changes and `irq_o` is low. Capture uses the master value that was in effect before the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Interrupt source inputs, synchronous to clk |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] select the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is an edge source whose rising input arrives in the same cycle as an acknowledge of that bit. The stimulus table drives this directly: it holds the source low, then raises it on the same clock that carries the acknowledge write, and reads status afterwards. A second hard case is a change to master control in the same cycle as an input change. The table staggers master writes against source transitions so that the one-cycle lag in capture gating can be seen through status reads.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int REG_IDX_W = 3;
    localparam int REG_IDX_LSB = 2;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_STAT   = 3'd0,
        IDX_PEND   = 3'd1,
        IDX_EN     = 3'd2,
        IDX_ACK    = 3'd3,
        IDX_SETEN  = 3'd4,
        IDX_CLREN  = 3'd5,
        IDX_VEC    = 3'd6,
        IDX_MASTER = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic stat_wr;
        logic ack_wr;
        logic en_wr;
        logic seten_wr;
        logic clren_wr;
        logic master_wr;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(logic wr, logic in_range, reg_idx_e idx);
        wr_dec_t d;
        logic    go;
        go          = wr && in_range;
        d.stat_wr   = go && (idx == IDX_STAT);
        d.ack_wr    = go && (idx == IDX_ACK);
        d.en_wr     = go && (idx == IDX_EN);
        d.seten_wr  = go && (idx == IDX_SETEN);
        d.clren_wr  = go && (idx == IDX_CLREN);
        d.master_wr = go && (idx == IDX_MASTER);
        return d;
    endfunction

endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
    parameter int              N    = 32,
    parameter logic [N-1:0]    KIND = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    input  logic         cap_en,
    input  logic         wr_stat,
    input  logic         wr_ack,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status
);

    logic [N-1:0] src_q;
    logic [N-1:0] base;
    logic [N-1:0] nxt;
    logic [N-1:0] edge_hit;

    always_comb begin
        if (wr_stat)     base = wdata;
        else if (wr_ack) base = status & ~wdata;
        else             base = status;
    end

    assign edge_hit = src & ~src_q & KIND & {N{cap_en}};

    for (genvar g = 0; g < N; g++) begin : g_bit
        if (KIND[g]) begin : g_edge
            assign nxt[g] = edge_hit[g] ? 1'b1 : base[g];
        end else begin : g_level
            assign nxt[g] = cap_en ? src[g] : base[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            src_q  <= '0;
        end else begin
            status <= nxt;
            src_q  <= src;
        end
    end

    // R9: a detected rising edge is recorded even when acknowledged in the same cycle
    a_r9_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (!wr_stat) |=> ((status & $past(edge_hit)) == $past(edge_hit)));

    // R8: level sources follow the input while capture is on
    a_r8_level_follow: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> ((status & ~KIND) == ($past(src) & ~KIND)));

    // R10: status is frozen when capture is off and no bus write touches it
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !wr_stat && !wr_ack) |=> $stable(status));

    // R5: acknowledge clears the written ones when nothing competes
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && !cap_en && !wr_stat) |=> ((status & $past(wdata)) == '0));

endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N     = 32,
    parameter int VEC_W = $clog2(N)
) (
    input  logic [N-1:0]     pend,
    output logic [VEC_W-1:0] idx,
    output logic             found
);

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx   = VEC_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl #(
    parameter int N  = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_seten,
    input  logic          wr_clren,
    input  logic          wr_master,
    input  logic [DW-1:0] wdata,
    output logic [N-1:0]  enable,
    output logic [DW-1:0] master
);

    logic [N-1:0] wd_n;
    assign wd_n = wdata[N-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            master <= '0;
        end else begin
            if (wr_en)         enable <= wd_n;
            else if (wr_seten) enable <= enable | wd_n;
            else if (wr_clren) enable <= enable & ~wd_n;
            if (wr_master)     master <= wdata;
        end
    end

    // R6: set-enable leaves every written one set
    a_r6_set_enable: assert property (@(posedge clk) disable iff (rst)
        wr_seten |=> ((enable & $past(wd_n)) == $past(wd_n)));

    // R6: clear-enable leaves every written one clear
    a_r6_clear_enable: assert property (@(posedge clk) disable iff (rst)
        wr_clren |=> ((enable & $past(wd_n)) == '0));

    // R6: atomic aliases leave the master register alone
    a_r6_master_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_seten || wr_clren) |=> $stable(master));

endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import intc_pkg::*;
#(
    parameter int           N_SRC     = 32,
    parameter int           DW        = 32,
    parameter int           ADDR_W    = 6,
    parameter logic [N_SRC-1:0] EDGE_KIND = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_o
);

    localparam int VEC_W   = $clog2(N_SRC);
    localparam int RANGE_B = REG_IDX_LSB + REG_IDX_W;

    logic             in_range;
    reg_idx_e         idx;
    wr_dec_t          dec;
    logic [N_SRC-1:0] status;
    logic [N_SRC-1:0] enable;
    logic [N_SRC-1:0] pending;
    logic [DW-1:0]    master;
    logic [VEC_W-1:0] vec_idx;
    logic             vec_found;
    logic             cap_en;
    logic             out_en;

    assign in_range = (bus_addr[ADDR_W-1:RANGE_B] == '0);
    assign idx      = reg_idx_e'(bus_addr[REG_IDX_LSB +: REG_IDX_W]);
    assign dec      = decode_write(bus_wr, in_range, idx);
    assign cap_en   = master[1];
    assign out_en   = master[0];

    intc_capture #(.N(N_SRC), .KIND(EDGE_KIND)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .src     (src_i),
        .cap_en  (cap_en),
        .wr_stat (dec.stat_wr),
        .wr_ack  (dec.ack_wr),
        .wdata   (bus_wdata[N_SRC-1:0]),
        .status  (status)
    );

    intc_ctrl #(.N(N_SRC), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (dec.en_wr),
        .wr_seten  (dec.seten_wr),
        .wr_clren  (dec.clren_wr),
        .wr_master (dec.master_wr),
        .wdata     (bus_wdata),
        .enable    (enable),
        .master    (master)
    );

    assign pending = status & enable;

    intc_prio #(.N(N_SRC), .VEC_W(VEC_W)) u_prio (
        .pend  (pending),
        .idx   (vec_idx),
        .found (vec_found)
    );

    assign irq_o = out_en && cap_en && (pending != '0);

    always_comb begin
        bus_rdata = '0;
        if (in_range) begin
            unique case (idx)
                IDX_STAT:   bus_rdata[N_SRC-1:0] = status;
                IDX_PEND:   bus_rdata[N_SRC-1:0] = pending;
                IDX_EN:     bus_rdata[N_SRC-1:0] = enable;
                IDX_VEC: begin
                    if (vec_found) bus_rdata[VEC_W-1:0] = vec_idx;
                    else           bus_rdata = '1;
                end
                IDX_MASTER: bus_rdata = master;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R10: request line stays low while capture is disabled
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
        !master[1] |-> !irq_o);

    // R3: encoder reports no vector exactly when nothing is pending
    a_r3_idle_vector: assert property (@(posedge clk) disable iff (rst)
        (pending == '0) |-> !vec_found);

    // R3: reported vector is pending and nothing lower is
    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        vec_found |-> (pending[vec_idx] &&
                       ((pending & ((N_SRC'(1) << vec_idx) - N_SRC'(1))) == '0)));

    // R7: out-of-range writes leave enable and master untouched
    a_r7_oor_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !in_range) |=> ($stable(enable) && $stable(master)));

endmodule

// File: tb/test_vec_intc.sv
`timescale 1ns/1ps
module test_vec_intc;

    localparam int N_SRC  = 32;
    localparam int DW     = 32;
    localparam int ADDR_W = 6;
    localparam logic [31:0] KIND = 32'h0000_FF00;
    localparam int NSTEP  = 22;
    localparam int SW     = 1 + 6 + 32 + 32 + 6 + 32 + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_SRC-1:0]  src_i = '0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic              irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vec_intc #(.N_SRC(N_SRC), .DW(DW), .ADDR_W(ADDR_W), .EDGE_KIND(KIND)) i_vec_intc (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // step: {wr, waddr, wdata, src, raddr, expected rdata, expected irq}
    localparam logic [SW-1:0] STEPS [NSTEP] = '{
        {1'b1, 6'h1C, 32'h0000_0003, 32'h0000_0000, 6'h1C, 32'h0000_0003, 1'b0},
        {1'b1, 6'h10, 32'h0000_0105, 32'h0000_0000, 6'h08, 32'h0000_0105, 1'b0},
        {1'b1, 6'h14, 32'h0000_0004, 32'h0000_0000, 6'h08, 32'h0000_0101, 1'b0},
        {1'b0, 6'h00, 32'h0000_0000, 32'h0000_0001, 6'h00, 32'h0000_0001, 1'b1},
        {1'b0, 6'h00, 32'h0000_0000, 32'h0000_0001, 6'h18, 32'h0000_0000, 1'b1},
        {1'b0, 6'h00, 32'h0000_0000, 32'h0000_0000, 6'h04, 32'h0000_0000, 1'b0},
        {1'b0, 6'h00, 32'h0000_0000, 32'h0000_0100, 6'h18, 32'h0000_0008, 1'b1},
        {1'b0, 6'h00, 32'h0000_0000, 32'h0000_0000, 6'h00, 32'h0000_0100, 1'b1},
        {1'b1, 6'h0C, 32'h0000_0100, 32'h0000_0000, 6'h18, 32'hFFFF_FFFF, 1'b0},
        {1'b1, 6'h1C, 32'h0000_0002, 32'h0000_0001, 6'h04, 32'h0000_0001, 1'b0},
        {1'b1, 6'h1C, 32'h0000_0001, 32'h0000_0001, 6'h00, 32'h0000_0001, 1'b0},
        {1'b0, 6'h00, 32'h0000_0000, 32'h0000_0000, 6'h00, 32'h0000_0001, 1'b0},
        {1'b1, 6'h1C, 32'h0000_0003, 32'h0000_0000, 6'h00, 32'h0000_0001, 1'b1},
        {1'b0, 6'h00, 32'h0000_0000, 32'h0000_0000, 6'h00, 32'h0000_0000, 1'b0},
        {1'b1, 6'h00, 32'h0000_0300, 32'h0000_0000, 6'h00, 32'h0000_0300, 1'b1},
        {1'b1, 6'h08, 32'h0000_0200, 32'h0000_0000, 6'h18, 32'h0000_0009, 1'b1},
        {1'b1, 6'h0C, 32'h0000_0300, 32'h0000_0000, 6'h18, 32'hFFFF_FFFF, 1'b0},
        {1'b1, 6'h04, 32'h0000_FFFF, 32'h0000_0000, 6'h04, 32'h0000_0000, 1'b0},
        {1'b1, 6'h20, 32'h0000_FFFF, 32'h0000_0000, 6'h20, 32'h0000_0000, 1'b0},
        {1'b1, 6'h0C, 32'h0000_0200, 32'h0000_0200, 6'h00, 32'h0000_0200, 1'b1},
        {1'b1, 6'h10, 32'hFFFF_FFFF, 32'h0000_0230, 6'h18, 32'h0000_0004, 1'b1},
        {1'b1, 6'h0C, 32'h0000_0230, 32'h0000_0230, 6'h00, 32'h0000_0030, 1'b1}
    };

    function automatic string step_tag(int s);
        case (s)
            0:       return "R7 master write";
            1:       return "R6 set-enable";
            2:       return "R6 clear-enable";
            3:       return "R8 level capture";
            4:       return "R3 vector bit0";
            5:       return "R2 level drop";
            6:       return "R9 edge capture";
            7:       return "R9 edge hold";
            8:       return "R5 acknowledge";
            9:       return "R4 output gate";
            10:      return "R10 lagged gate";
            11:      return "R10 frozen status";
            12:      return "R10 capture off at edge";
            13:      return "R8 resumed capture";
            14:      return "R7 status write";
            15:      return "R3 vector bit9";
            16:      return "R3 idle vector";
            17:      return "R2 pending write";
            18:      return "R7 out of range";
            19:      return "R9 capture beats ack";
            20:      return "R3 lowest of two";
            default: return "R9 held input no recapture";
        endcase
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic read_check(input string tag, input logic [ADDR_W-1:0] a, input logic [DW-1:0] exp);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic reset_checks(input string tag);
        read_check({tag, " status"}, 6'h00, 32'h0);
        read_check({tag, " pending"}, 6'h04, 32'h0);
        read_check({tag, " enable"}, 6'h08, 32'h0);
        read_check({tag, " ack"}, 6'h0C, 32'h0);
        read_check({tag, " set-en"}, 6'h10, 32'h0);
        read_check({tag, " clr-en"}, 6'h14, 32'h0);
        read_check({tag, " vector"}, 6'h18, 32'hFFFF_FFFF);
        read_check({tag, " master"}, 6'h1C, 32'h0);
        check({tag, " irq"}, {31'b0, irq_o}, 32'h0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        reset_checks("R1 reset");

        for (int s = 0; s < NSTEP; s++) begin
            logic [SW-1:0] st;
            st = STEPS[s];
            @(negedge clk);
            bus_wr    = st[109];
            bus_addr  = st[108:103];
            bus_wdata = st[102:71];
            src_i     = st[70:39];
            @(posedge clk);
            #1;
            bus_wr   = 1'b0;
            bus_addr = st[38:33];
            #1;
            check(step_tag(s), bus_rdata, st[32:1]);
            check({step_tag(s), " irq R4"}, {31'b0, irq_o}, {31'b0, st[0]});
        end

        // R1: reset in the middle of activity
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        reset_checks("R1 mid-run reset");

        // R10: inputs ignored after reset because capture is off
        @(negedge clk);
        src_i = 32'h0000_0001;
        @(negedge clk);
        read_check("R10 no capture after reset", 6'h00, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule